// File: doc/BRIEF.md
# SDRAM Bank State Monitor

This block watches an SDRAM command bus without driving it. On every rising clock edge it samples the clock enable, the active-low select and strobe lines, the two bank-select bits, the auto-precharge address bit and the byte mask. From these it decodes the command and keeps a model of all four banks. For each bank it records whether a row is open, and it keeps a small set of clock-count timers: activate to column command, activate to activate, precharge to activate, and the length of a burst with auto precharge.

Whenever a command breaks the protocol, the block raises an error flag and stores a code that names the kind of violation. Both stay set until reset, so the code always shows the first violation. The block also tracks the byte mask for both directions. On a write the mask takes effect in the same clock. On a read it forces the output to high impedance two sampled clocks later.

The block can sit beside a memory model in a self-checking testbench, or next to a controller in silicon as a protocol guard. It does not model any data storage.

Top module: `sdram_bus_monitor`

## Requirements
- R1: A command is decoded only when `cke` is high and `cs_n` is low. It is encoded as {ras_n, cas_n, we_n}: 000 mode set, 001 refresh, 010 precharge, 011 activate, 100 write, 101 read, 110 burst stop, 111 no-operation. With `cs_n` high the strobes are ignored and the clock counts as a no-operation.
- R2: The bank index is {ba[1], ba[0]}, and `bank_open[i]` reflects bank i. An activate opens the selected bank. A precharge closes it. A precharge with `a10` high closes every bank.
- R3: An activate to an open bank is error code 1. A read or write to an idle bank is error code 2.
- R4: A read or write issued fewer than T_RCD (2) clocks after the activate of its bank is error code 3.
- R5: An activate issued fewer than T_RC (7) clocks after the previous activate of the same bank is error code 4. Code 1 takes priority over code 4.
- R6: An activate issued fewer than T_RP (2) clocks after a precharge closed that bank is error code 5. Codes 1 and 4 take priority over code 5.
- R7: A read or write with `a10` high to an open bank starts an auto-precharge burst of BURST (4) clocks. The bank reads as closed from BURST clocks after the command. A read or write to any bank in the BURST-1 clocks after that command is error code 6, and code 6 takes priority over codes 2 and 3. An activate of that bank earlier than BURST+T_RP clocks after the command is error code 5.
- R8: A mode set or refresh while any bank is open is error code 7. Any command other than no-operation in the 2 clocks after a mode set is error code 8, and code 8 takes priority over every other code.
- R9: Column commands to an open bank may follow each other on every clock without error.
- R10: `err` rises in the clock after the first violation. From then until reset, `err` stays high and `err_code` keeps the code of that first violation.
- R11: `wr_mask` equals `dqm` in the same clock (write latency 0). `rd_hiz` equals the `dqm` value sampled two enabled clocks earlier (read latency 2).
- R12: While `cke` is low, the command is ignored and all timers, bank states and the read mask pipeline hold their values.
- R13: After reset, all banks are idle, `err` is 0, `err_code` is 0 and `rd_hiz` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all inputs sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable; low freezes the monitor |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select {ba[1], ba[0]} |
| a10 | input | 1 | Auto-precharge / precharge-all bit |
| dqm | input | 8 | Byte mask |
| bank_open | output | 4 | One bit per bank, 1 when a row is open |
| wr_mask | output | 8 | Byte mask applied to write data this clock |
| rd_hiz | output | 8 | Byte mask forcing read data to high impedance this clock |
| err | output | 1 | Sticky violation flag |
| err_code | output | 4 | Code of the first violation, 0 when none |

## Verification
A wrong bank state or a timer off by one shows up at the ports in the clock right after the next command to that bank. It appears either as a spurious or a missing rise of `err`, or as the wrong `err_code`. A stale open bit is visible directly on `bank_open`, and an auto-precharge close that comes one clock early or late shows up there on that exact clock. A read-mask pipeline of the wrong depth, or one that shifts during a clock-enable freeze, shows up on `rd_hiz` within two clocks.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

    localparam int BANK_W = 2;

    typedef enum logic [2:0] {
        CMD_MRS = 3'b000,
        CMD_REF = 3'b001,
        CMD_PRE = 3'b010,
        CMD_ACT = 3'b011,
        CMD_WR  = 3'b100,
        CMD_RD  = 3'b101,
        CMD_BST = 3'b110,
        CMD_NOP = 3'b111
    } cmd_e;

    typedef enum logic [3:0] {
        ERR_NONE     = 4'd0,
        ERR_ACT_OPEN = 4'd1,
        ERR_COL_IDLE = 4'd2,
        ERR_RCD      = 4'd3,
        ERR_RC       = 4'd4,
        ERR_RP       = 4'd5,
        ERR_AP_BURST = 4'd6,
        ERR_NOT_IDLE = 4'd7,
        ERR_MRS_WAIT = 4'd8
    } err_e;

    typedef struct packed {
        cmd_e              cmd;
        logic [BANK_W-1:0] bank;
        logic              a10;
    } cmd_t;

    typedef struct packed {
        logic open;
        logic rcd_busy;
        logic rc_busy;
        logic rp_busy;
        logic ap_busy;
    } bank_stat_t;

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic is_column(cmd_e c);
        return (c == CMD_RD) || (c == CMD_WR);
    endfunction

    // One command per clock, so at most one rule family applies.
    function automatic err_e classify(cmd_e c, bank_stat_t sel, logic any_open,
                                      logic any_ap, logic mrs_wait);
        if (mrs_wait && c != CMD_NOP) return ERR_MRS_WAIT;
        case (c)
            CMD_ACT: begin
                if (sel.open)    return ERR_ACT_OPEN;
                if (sel.rc_busy) return ERR_RC;
                if (sel.rp_busy) return ERR_RP;
                return ERR_NONE;
            end
            CMD_RD, CMD_WR: begin
                if (any_ap)       return ERR_AP_BURST;
                if (!sel.open)    return ERR_COL_IDLE;
                if (sel.rcd_busy) return ERR_RCD;
                return ERR_NONE;
            end
            CMD_MRS, CMD_REF: return any_open ? ERR_NOT_IDLE : ERR_NONE;
            default: return ERR_NONE;
        endcase
    endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_mon_pkg::*;
(
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BANK_W-1:0] ba,
    input  logic              a10,
    output cmd_t              cmd
);

    always_comb begin
        cmd.bank = ba;
        cmd.a10  = a10;
        if (cke && !cs_n) cmd.cmd = cmd_e'({ras_n, cas_n, we_n});
        else              cmd.cmd = CMD_NOP;
    end

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
    import sdram_mon_pkg::*;
#(
    parameter int T_RCD = 2,
    parameter int T_RC  = 7,
    parameter int T_RP  = 2,
    parameter int BURST = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  cmd_t       cmd_i,
    input  logic       hit,
    output bank_stat_t stat
);

    localparam int MAXV = imax(imax(T_RCD, T_RC), imax(T_RP, BURST));
    localparam int CW   = $clog2(MAXV + 1);

    logic [CW-1:0] rcd_q, rc_q, rp_q, ap_q;
    logic          open_q;

    function automatic logic [CW-1:0] dn(logic [CW-1:0] v);
        return (v == '0) ? v : v - 1'b1;
    endfunction

    logic act_hit, pre_hit, col_ap, ap_done;
    assign act_hit = hit && (cmd_i.cmd == CMD_ACT);
    assign pre_hit = (cmd_i.cmd == CMD_PRE) && (hit || cmd_i.a10);
    assign col_ap  = hit && is_column(cmd_i.cmd) && cmd_i.a10 && open_q;
    assign ap_done = (ap_q == CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            rcd_q  <= '0;
            rc_q   <= '0;
            rp_q   <= '0;
            ap_q   <= '0;
        end else if (en) begin
            rcd_q <= act_hit ? CW'(T_RCD - 1) : dn(rcd_q);
            rc_q  <= act_hit ? CW'(T_RC - 1)  : dn(rc_q);

            if (pre_hit)     ap_q <= '0;
            else if (col_ap) ap_q <= CW'(BURST - 1);
            else             ap_q <= dn(ap_q);

            if (pre_hit && open_q)        rp_q <= CW'(T_RP - 1);
            else if (ap_done && !act_hit) rp_q <= CW'(T_RP);
            else                          rp_q <= dn(rp_q);

            if (act_hit)      open_q <= 1'b1;
            else if (pre_hit) open_q <= 1'b0;
            else if (ap_done) open_q <= 1'b0;
        end
    end

    assign stat.open     = open_q;
    assign stat.rcd_busy = (rcd_q != '0);
    assign stat.rc_busy  = (rc_q != '0);
    assign stat.rp_busy  = (rp_q != '0);
    assign stat.ap_busy  = (ap_q != '0);

endmodule

// File: rtl/sdram_dqm_pipe.sv
module sdram_dqm_pipe #(
    parameter int W   = 8,
    parameter int LAT = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] dqm_i,
    output logic [W-1:0] hiz_o
);

    generate
        if (LAT == 0) begin : g_direct
            assign hiz_o = dqm_i;
        end else begin : g_shift
            logic [W-1:0] stg [LAT];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < LAT; i++) stg[i] <= '0;
                end else if (en) begin
                    stg[0] <= dqm_i;
                    for (int i = 1; i < LAT; i++) stg[i] <= stg[i-1];
                end
            end
            assign hiz_o = stg[LAT-1];
        end
    endgenerate

endmodule

// File: rtl/sdram_bus_monitor.sv
module sdram_bus_monitor
    import sdram_mon_pkg::*;
#(
    parameter int DQM_W      = 8,
    parameter int T_RCD      = 2,
    parameter int T_RC       = 7,
    parameter int T_RP       = 2,
    parameter int BURST      = 4,
    parameter int RD_DQM_LAT = 2,
    parameter int MRS_GAP    = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cke,
    input  logic                        cs_n,
    input  logic                        ras_n,
    input  logic                        cas_n,
    input  logic                        we_n,
    input  logic [BANK_W-1:0]           ba,
    input  logic                        a10,
    input  logic [DQM_W-1:0]            dqm,
    output logic [(1 << BANK_W)-1:0]    bank_open,
    output logic [DQM_W-1:0]            wr_mask,
    output logic [DQM_W-1:0]            rd_hiz,
    output logic                        err,
    output logic [3:0]                  err_code
);

    localparam int NUM_BANKS = 1 << BANK_W;
    localparam int MW        = $clog2(MRS_GAP + 1);

    cmd_t       cmd;
    bank_stat_t stat_arr [NUM_BANKS];
    logic [NUM_BANKS-1:0] open_v, ap_v;

    sdram_cmd_decode u_dec (
        .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .a10(a10), .cmd(cmd)
    );

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            logic hit;
            assign hit = (cmd.bank == BANK_W'(b));
            sdram_bank_tracker #(
                .T_RCD(T_RCD), .T_RC(T_RC), .T_RP(T_RP), .BURST(BURST)
            ) u_trk (
                .clk(clk), .rst(rst), .en(cke), .cmd_i(cmd), .hit(hit),
                .stat(stat_arr[b])
            );
            assign open_v[b] = stat_arr[b].open;
            assign ap_v[b]   = stat_arr[b].ap_busy;
        end
    endgenerate

    assign bank_open = open_v;

    // Quiet window after a mode set
    logic [MW-1:0] mrs_q;
    always_ff @(posedge clk) begin
        if (rst)                      mrs_q <= '0;
        else if (cke) begin
            if (cmd.cmd == CMD_MRS)   mrs_q <= MW'(MRS_GAP);
            else if (mrs_q != '0)     mrs_q <= mrs_q - 1'b1;
        end
    end

    err_e code_now;
    assign code_now = classify(cmd.cmd, stat_arr[cmd.bank], |open_v, |ap_v,
                               mrs_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            err      <= 1'b0;
            err_code <= 4'd0;
        end else if (!err && code_now != ERR_NONE) begin
            err      <= 1'b1;
            err_code <= code_now;
        end
    end

    assign wr_mask = dqm;

    sdram_dqm_pipe #(.W(DQM_W), .LAT(RD_DQM_LAT)) u_dqm (
        .clk(clk), .rst(rst), .en(cke), .dqm_i(dqm), .hiz_o(rd_hiz)
    );

endmodule

// File: rtl/sdram_mon_checker.sv
module sdram_mon_checker #(
    parameter int DQM_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             cke,
    input logic             cs_n,
    input logic             ras_n,
    input logic             cas_n,
    input logic             we_n,
    input logic [1:0]       ba,
    input logic             a10,
    input logic [DQM_W-1:0] dqm,
    input logic [3:0]       bank_open,
    input logic [DQM_W-1:0] rd_hiz,
    input logic             err,
    input logic [3:0]       err_code
);

    logic [1:0] since;
    always_ff @(posedge clk) begin
        if (rst)              since <= 2'd0;
        else if (since != 2'd3) since <= since + 2'd1;
    end

    logic sel, is_act, is_pre, is_col, is_mrs;
    assign sel    = cke && !cs_n;
    assign is_act = sel && {ras_n, cas_n, we_n} == 3'b011;
    assign is_pre = sel && {ras_n, cas_n, we_n} == 3'b010;
    assign is_col = sel && ({ras_n, cas_n, we_n} == 3'b100 || {ras_n, cas_n, we_n} == 3'b101);
    assign is_mrs = sel && {ras_n, cas_n, we_n} == 3'b000;

    p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        err |=> err && $stable(err_code));

    p_act_opens_r2: assert property (@(posedge clk) disable iff (rst)
        is_act |=> bank_open[$past(ba)]);

    p_pre_all_r2: assert property (@(posedge clk) disable iff (rst)
        is_pre && a10 |=> bank_open == 4'b0000);

    p_act_open_r3: assert property (@(posedge clk) disable iff (rst)
        is_act && bank_open[ba] && !err |=> err && err_code == 4'd1);

    p_col_idle_r3: assert property (@(posedge clk) disable iff (rst)
        is_col && !bank_open[ba] && !err |=> err);

    p_mrs_busy_r8: assert property (@(posedge clk) disable iff (rst)
        is_mrs && bank_open != 4'b0000 && !err |=> err);

    p_freeze_r12: assert property (@(posedge clk) disable iff (rst)
        !cke |=> $stable(bank_open) && $stable(rd_hiz));

    p_rd_lat_r11: assert property (@(posedge clk) disable iff (rst)
        since >= 2'd2 && $past(cke) && $past(cke, 2) |-> rd_hiz == $past(dqm, 2));

endmodule

bind sdram_bus_monitor sdram_mon_checker #(.DQM_W(DQM_W)) u_chk (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10), .dqm(dqm),
    .bank_open(bank_open), .rd_hiz(rd_hiz), .err(err), .err_code(err_code)
);

// File: tb/tb_sdram_bus_monitor.sv
module tb_sdram_bus_monitor;
    import sdram_mon_pkg::*;

    localparam int TRCD = 2, TRC = 7, TRP = 2, BL = 4;

    logic clk = 1'b0, rst = 1'b1, cke = 1'b1, cs_n = 1'b1;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
    logic [1:0] ba = 2'd0;
    logic [7:0] dqm = 8'h00;
    logic [3:0] bank_open, err_code;
    logic [7:0] wr_mask, rd_hiz;
    logic err;

    always #5 clk = ~clk;

    sdram_bus_monitor dut (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10), .dqm(dqm),
        .bank_open(bank_open), .wr_mask(wr_mask), .rd_hiz(rd_hiz),
        .err(err), .err_code(err_code)
    );

    int n_checks = 0, n_fail = 0;

    // reference state, timestamps in enabled clocks
    int m_n, m_mrsok, m_code;
    int m_tact [4], m_preok [4], m_apend [4];
    bit m_open [4], m_ap [4];
    bit m_err;
    logic [7:0] m_d1, m_d2;

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_n = 0; m_mrsok = 0; m_code = 0; m_err = 0; m_d1 = 0; m_d2 = 0;
        for (int b = 0; b < 4; b++) begin
            m_tact[b] = -100; m_preok[b] = 0; m_apend[b] = 0;
            m_open[b] = 0; m_ap[b] = 0;
        end
    endtask

    function automatic int model_code(logic [2:0] op, int b);
        bit any_open = 0, any_ap = 0;
        for (int i = 0; i < 4; i++) begin
            any_open |= m_open[i];
            any_ap   |= m_ap[i];
        end
        if (m_n < m_mrsok && op != CMD_NOP) return 8;
        if (op == CMD_ACT) begin
            if (m_open[b])              return 1;
            if (m_n < m_tact[b] + TRC)  return 4;
            if (m_n < m_preok[b])       return 5;
        end else if (op == CMD_RD || op == CMD_WR) begin
            if (any_ap)                 return 6;
            if (!m_open[b])             return 2;
            if (m_n < m_tact[b] + TRCD) return 3;
        end else if (op == CMD_MRS || op == CMD_REF) begin
            if (any_open)               return 7;
        end
        return 0;
    endfunction

    task automatic model_step(bit k, bit c, logic [2:0] op_in, int b, bit ap, logic [7:0] dq);
        logic [2:0] op;
        int code;
        if (!k) return;
        op = c ? 3'(CMD_NOP) : op_in;
        code = model_code(op, b);
        if (!m_err && code != 0) begin m_err = 1; m_code = code; end
        if (op == CMD_ACT) begin
            m_open[b] = 1; m_tact[b] = m_n;
        end else if (op == CMD_PRE) begin
            for (int i = 0; i < 4; i++)
                if ((i == b || ap) && m_open[i]) begin
                    m_open[i] = 0; m_ap[i] = 0; m_preok[i] = m_n + TRP;
                end
        end else if ((op == CMD_RD || op == CMD_WR) && ap && m_open[b]) begin
            m_ap[b] = 1; m_apend[b] = m_n + BL; m_preok[b] = m_n + BL + TRP;
        end else if (op == CMD_MRS) begin
            m_mrsok = m_n + 3;
        end
        m_d2 = m_d1; m_d1 = dq;
        m_n++;
        for (int i = 0; i < 4; i++)
            if (m_ap[i] && m_n >= m_apend[i]) begin m_ap[i] = 0; m_open[i] = 0; end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic drive(bit k, bit c, logic [2:0] op, int b, bit ap, logic [7:0] dq);
        logic [3:0] exp_open;
        cke = k; cs_n = c; {ras_n, cas_n, we_n} = op; ba = 2'(b); a10 = ap; dqm = dq;
        #1;
        chk("R11 wr_mask", wr_mask, dq);
        @(posedge clk);
        model_step(k, c, op, b, ap, dq);
        @(negedge clk);
        chk("R10 err", err, m_err);
        chk("R10 err_code", err_code, m_code);
        chk("R11 rd_hiz", rd_hiz, m_d2);
        exp_open = {m_open[3], m_open[2], m_open[1], m_open[0]};
        if (!m_err) chk("R2 bank_open", bank_open, exp_open);
    endtask

    task automatic op1(logic [2:0] op, int b, bit ap);
        drive(1, 0, op, b, ap, 8'h00);
    endtask
    task automatic nops(int n);
        for (int i = 0; i < n; i++) drive(1, 1, 3'b111, 0, 0, 8'h00);
    endtask

    task automatic do_reset();
        rst = 1; cke = 1; cs_n = 1; {ras_n, cas_n, we_n} = 3'b111; dqm = 0; a10 = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        model_reset();
    endtask

    bit done = 0;
    initial begin
        #1_500_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        do_reset();
        // R13 reset state
        chk("R13 bank_open", bank_open, 0);
        chk("R13 err", err, 0);
        chk("R13 err_code", err_code, 0);
        chk("R13 rd_hiz", rd_hiz, 0);

        // R2 R9 back-to-back column traffic, then precharge all
        op1(CMD_ACT, 1, 0); nops(1);
        op1(CMD_RD, 1, 0); op1(CMD_WR, 1, 0); op1(CMD_RD, 1, 0);
        chk("R9 no error", err, 0);
        chk("R2 bank1 open", bank_open, 4'b0010);
        op1(CMD_ACT, 3, 0); nops(1);
        op1(CMD_PRE, 0, 1);
        chk("R2 precharge all", bank_open, 0);

        do_reset(); op1(CMD_ACT, 2, 0); op1(CMD_ACT, 2, 0);
        chk("R3 act open", err_code, 1);
        do_reset(); op1(CMD_RD, 0, 0);
        chk("R3 column idle", err_code, 2);
        do_reset(); op1(CMD_ACT, 0, 0); op1(CMD_RD, 0, 0);
        chk("R4 rcd", err_code, 3);
        do_reset(); op1(CMD_ACT, 0, 0); nops(1); op1(CMD_PRE, 0, 0); nops(1); op1(CMD_ACT, 0, 0);
        chk("R5 rc", err_code, 4);
        do_reset(); op1(CMD_ACT, 0, 0); nops(6); op1(CMD_PRE, 0, 0); op1(CMD_ACT, 0, 0);
        chk("R6 rp", err_code, 5);

        // R7 auto precharge
        do_reset(); op1(CMD_ACT, 0, 0); op1(CMD_ACT, 1, 0); op1(CMD_RD, 0, 1); op1(CMD_RD, 1, 0);
        chk("R7 column during burst", err_code, 6);
        do_reset(); op1(CMD_ACT, 0, 0); nops(1); op1(CMD_WR, 0, 1); nops(2);
        chk("R7 still open", bank_open, 4'b0001);
        nops(1);
        chk("R7 closed after burst", bank_open, 0);
        nops(2); op1(CMD_ACT, 0, 0);
        chk("R7 reactivate on time", err, 0);
        do_reset(); op1(CMD_ACT, 0, 0); nops(1); op1(CMD_WR, 0, 1); nops(4); op1(CMD_ACT, 0, 0);
        chk("R7 reactivate early", err_code, 5);

        // R8 mode set and refresh
        do_reset(); op1(CMD_ACT, 0, 0); op1(CMD_MRS, 0, 0);
        chk("R8 mode set while open", err_code, 7);
        do_reset(); op1(CMD_ACT, 1, 0); nops(1); op1(CMD_REF, 0, 0);
        chk("R8 refresh while open", err_code, 7);
        do_reset(); op1(CMD_MRS, 0, 0); op1(CMD_ACT, 0, 0);
        chk("R8 mode set gap", err_code, 8);
        do_reset(); op1(CMD_MRS, 0, 0); nops(2); op1(CMD_ACT, 0, 0);
        chk("R8 after gap", err, 0);

        // R10 first code kept
        do_reset(); op1(CMD_ACT, 0, 0); op1(CMD_ACT, 0, 0); op1(CMD_RD, 2, 0); nops(3);
        chk("R10 sticky err", err, 1);
        chk("R10 first code", err_code, 1);

        // R1 chip select high ignores strobes
        do_reset(); drive(1, 1, CMD_ACT, 0, 0, 8'h00); drive(1, 1, CMD_RD, 3, 0, 8'h00);
        chk("R1 cs high ignored", bank_open, 0);
        chk("R1 cs high no error", err, 0);

        // R11 mask latencies, R12 freeze
        do_reset();
        drive(1, 1, CMD_NOP, 0, 0, 8'h11);
        drive(1, 1, CMD_NOP, 0, 0, 8'h22);
        chk("R11 read latency", rd_hiz, 8'h11);
        drive(0, 0, CMD_ACT, 0, 0, 8'h33);
        drive(0, 0, CMD_ACT, 0, 0, 8'h44);
        chk("R12 mask frozen", rd_hiz, 8'h11);
        chk("R12 command ignored", bank_open, 0);
        drive(1, 1, CMD_NOP, 0, 0, 8'h55);
        chk("R11 resumes", rd_hiz, 8'h22);

        // constrained random against the reference
        for (int s = 0; s < 150; s++) begin
            do_reset();
            for (int i = 0; i < 40; i++) begin
                int r = $urandom % 16;
                logic [2:0] op;
                if (r < 6)       op = CMD_NOP;
                else if (r < 8)  op = CMD_ACT;
                else if (r < 10) op = CMD_RD;
                else if (r == 10) op = CMD_WR;
                else if (r == 11) op = CMD_PRE;
                else if (r == 12) op = CMD_BST;
                else if (r == 13) op = CMD_MRS;
                else if (r == 14) op = CMD_REF;
                else             op = CMD_ACT;
                drive(($urandom % 10) != 0, ($urandom % 5) == 0, op,
                      int'($urandom % 4), ($urandom % 3) == 0, 8'($urandom));
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule